// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block holds the burst and byte-write control of a synchronous SRAM with a 36-bit word. The word is split into four 9-bit byte lanes, and each lane carries 8 data bits and 1 parity bit. A start strobe captures an external address and begins a four-beat burst. Each advance pulse then moves the low two address bits to the next beat. The upper address bits do not change during a burst.

The beat order is chosen when the burst starts:
- **Interleaved order:** the low bits are the start bits XORed with the beat count.
- **Linear order:** the low bits count up by one and wrap modulo 4.

Each access is either a read or a write. On a read, the stored word appears at a registered output one clock after the address is presented. On a write, four active-low lane enables pick which lanes of the small internal array are updated. Any combination of lanes is allowed, including no lanes at all.

Top module: `burst_sram_seq`

## Requirements
- R1: After reset, `acc_addr_o`, `beat_o` and `rdata_o` are all zero.
- R2: A cycle with `start_i` high is an access at `addr_i`. After that edge, `acc_addr_o` equals `addr_i` and `beat_o` is 0. This holds even when `adv_i` is high in the same cycle, because the start takes precedence.
- R3: When `order_i` is 1 at the start, beat k accesses a word whose low two bits are the start's low bits XOR k. For example, a start of 01 gives 01, 00, 11, 10.
- R4: When `order_i` is 0 at the start, beat k accesses a word whose low two bits are (start + k) mod 4. For example, a start of 10 gives 10, 11, 00, 01.
- R5: An `adv_i` cycle without `start_i` is an access at the next beat, and `beat_o` increases by one modulo 4. Address bits above bit 1 keep their start value. The advance after beat 3 returns to the start address.
- R6: An access with `wr_ni` high is a read. The values of `lane_wr_ni` and `wdata_i` have no effect on it. `rdata_o` shows the stored word after the same clock edge, and the memory is left unchanged.
- R7: A write access (`wr_ni` low) with all four bits of `lane_wr_ni` high leaves the memory unchanged.
- R8: In a write access, each low bit i of `lane_wr_ni` replaces bits [9i+8:9i] of the addressed word with the same bits of `wdata_i`. This includes the lane's parity bit 9i+8. Lanes whose enable bit is high keep their old value. `rdata_o` holds its value through a write.
- R9: In a cycle with neither `start_i` nor `adv_i`, nothing is accessed. `acc_addr_o`, `beat_o` and `rdata_o` hold, and the memory is unchanged whatever `wr_ni` and `lane_wr_ni` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load `addr_i` and start a burst |
| adv_i | input | 1 | Step to the next beat |
| addr_i | input | ADDR_W | Burst start address |
| order_i | input | 1 | Beat order, sampled at start: 1 interleaved, 0 linear |
| wr_ni | input | 1 | Active-low write enable |
| lane_wr_ni | input | 4 | Active-low per-lane write enables |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| rdata_o | output | 36 | Registered read data |
| acc_addr_o | output | ADDR_W | Address of the last access |
| beat_o | output | 2 | Beat index of the last access |

## Verification
Two pairs of functions can land in the same cycle.

**Restart during an advance.** A start and an advance can be asserted together while a burst is in progress. The bench drives both high in the middle of a burst. It checks that the access address and beat reflect only the new start, and that the returned word comes from the new address.

**Read with lane enables active.** A read can arrive while the lane enables are driven low. The bench issues such reads with fresh write data on `wdata_i`. It then reads the word back and confirms that it is unchanged.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  function automatic logic [BEAT_W-1:0] beat_low(input logic [BEAT_W-1:0] base,
                                                 input logic [BEAT_W-1:0] beat,
                                                 input burst_order_e ord);
    return (ord == ORD_XOR) ? (base ^ beat) : BEAT_W'(base + beat);
  endfunction
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  burst_order_e      order_i,
  output logic              access_o,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [BEAT_W-1:0] beat_o,
  output burst_order_e      order_o
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [ADDR_W-1:0] acc_q;
  burst_order_e      ord_q;

  assign access_o = start_i | adv_i;

  always_comb begin
    beat_d     = beat_q;
    eff_addr_o = acc_q;
    if (start_i) begin
      // start wins over a concurrent advance
      beat_d     = '0;
      eff_addr_o = addr_i;
    end else if (adv_i) begin
      beat_d     = BEAT_W'(beat_q + 1'b1);
      eff_addr_o = {base_q[ADDR_W-1:BEAT_W], beat_low(base_q[BEAT_W-1:0], beat_d, ord_q)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
      acc_q  <= '0;
      ord_q  <= ORD_LINEAR;
    end else begin
      if (start_i) begin
        base_q <= addr_i;
        ord_q  <= order_i;
      end
      if (access_o) begin
        beat_q <= beat_d;
        acc_q  <= eff_addr_o;
      end
    end
  end

  assign acc_addr_o = acc_q;
  assign beat_o     = beat_q;
  assign order_o    = ord_q;
endmodule

// File: rtl/lane_write_dec.sv
module lane_write_dec #(
  parameter int unsigned LANES = 4
) (
  input  logic             access_i,
  input  logic             wr_ni,
  input  logic [LANES-1:0] lane_wr_ni,
  output logic [LANES-1:0] lane_we_o,
  output logic             rd_o
);
  logic wr_cyc;
  assign wr_cyc = access_i & ~wr_ni;
  assign rd_o   = access_i & wr_ni;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we_o[g] = wr_cyc & ~lane_wr_ni[g];
  end
endmodule

// File: rtl/lane_mem.sv
module lane_mem #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];
  logic [LANE_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= mem_q[addr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_i,
  input  logic              wr_ni,
  input  logic [LANES-1:0]  lane_wr_ni,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  logic              access;
  logic              rd;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  lane_we;
  burst_order_e      ord_cur;
  logic              order_cur;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .adv_i      (adv_i),
    .addr_i     (addr_i),
    .order_i    (burst_order_e'(order_i)),
    .access_o   (access),
    .eff_addr_o (eff_addr),
    .acc_addr_o (acc_addr_o),
    .beat_o     (beat_o),
    .order_o    (ord_cur)
  );

  assign order_cur = (ord_cur == ORD_XOR);

  lane_write_dec #(.LANES(LANES)) u_dec (
    .access_i   (access),
    .wr_ni      (wr_ni),
    .lane_wr_ni (lane_wr_ni),
    .lane_we_o  (lane_we),
    .rd_o       (rd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (lane_we[g]),
      .re_i    (rd),
      .addr_i  (eff_addr),
      .wdata_i (wdata_i[g*LANE_W +: LANE_W]),
      .rdata_o (rdata_o[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/burst_sram_seq_chk.sv
module burst_sram_seq_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned WORD_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              adv_i,
  input logic              wr_ni,
  input logic              order_cur,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] acc_addr_o,
  input logic [1:0]        beat_o,
  input logic [WORD_W-1:0] rdata_o
);
  a_r2_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (acc_addr_o == $past(addr_i)) && (beat_o == 2'd0));

  a_r5_beat_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && adv_i) |=> beat_o == 2'($past(beat_o) + 2'd1));

  a_r5_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && adv_i) |=> acc_addr_o[ADDR_W-1:2] == $past(acc_addr_o[ADDR_W-1:2]));

  a_r4_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && adv_i && !order_cur) |=>
      acc_addr_o[1:0] == 2'($past(acc_addr_o[1:0]) + 2'd1));

  a_r3_xor_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && adv_i && order_cur) |=>
      acc_addr_o[1:0] == ($past(acc_addr_o[1:0]) ^ $past(beat_o) ^ 2'($past(beat_o) + 2'd1)));

  a_r8_write_holds_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((start_i || adv_i) && !wr_ni) |=> $stable(rdata_o));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !adv_i) |=> $stable(acc_addr_o) && $stable(beat_o) && $stable(rdata_o));
endmodule

bind burst_sram_seq burst_sram_seq_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .adv_i      (adv_i),
  .wr_ni      (wr_ni),
  .order_cur  (order_cur),
  .addr_i     (addr_i),
  .acc_addr_o (acc_addr_o),
  .beat_o     (beat_o),
  .rdata_o    (rdata_o)
);

// File: tb/burst_sram_seq_bench.sv
module burst_sram_seq_bench;
  localparam int AW = 8;
  localparam int WW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, adv = 1'b0, ord = 1'b0, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [3:0]    lanes_n = 4'hF;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic [AW-1:0] acc_addr;
  logic [1:0]    beat;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [WW-1:0] model [1<<AW];

  burst_sram_seq u_burst_sram_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .adv_i(adv), .addr_i(addr),
    .order_i(ord), .wr_ni(wr_n), .lane_wr_ni(lanes_n), .wdata_i(wdata),
    .rdata_o(rdata), .acc_addr_o(acc_addr), .beat_o(beat)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic a, input logic [AW-1:0] ad, input logic o,
                       input logic wn, input logic [3:0] ln, input logic [WW-1:0] wd);
    @(negedge clk);
    start = s; adv = a; addr = ad; ord = o; wr_n = wn; lanes_n = ln; wdata = wd;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [WW-1:0] seed_word(input logic [AW-1:0] a);
    return {a, ~a, a ^ 8'hA5, 4'h9, a + 8'd3};
  endfunction

  function automatic logic [WW-1:0] rnd_word();
    return {4'($urandom), $urandom};
  endfunction

  task automatic t_reset();
    chk("R1 rdata", 64'(rdata), 64'd0);
    chk("R1 addr", 64'(acc_addr), 64'd0);
    chk("R1 beat", 64'(beat), 64'd0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < (1 << AW); a++) begin
      drive(1, 0, AW'(a), 0, 0, 4'h0, seed_word(AW'(a)));
      model[a] = seed_word(AW'(a));
    end
    drive(1, 0, 8'h10, 0, 1, 4'hF, '0);
    chk("R8 full write readback", 64'(rdata), 64'(model[8'h10]));
  endtask

  task automatic t_burst(input logic o, input logic [1:0] s);
    logic [AW-1:0] base = {6'($urandom), s};
    logic [AW-1:0] exp_a;
    drive(1, 0, base, o, 1, 4'hF, '0);
    chk("R2 start addr", 64'(acc_addr), 64'(base));
    chk("R2 start beat", 64'(beat), 64'd0);
    chk("R6 start read", 64'(rdata), 64'(model[base]));
    for (int k = 1; k <= 4; k++) begin
      // order_i flipped mid-burst must not matter
      drive(0, 1, 8'hFF, ~o, 1, 4'h0, rnd_word());
      exp_a = {base[AW-1:2], o ? (s ^ 2'(k)) : 2'(s + 2'(k))};
      chk(o ? "R3 xor beat addr" : "R4 linear beat addr", 64'(acc_addr), 64'(exp_a));
      chk("R5 beat count", 64'(beat), 64'(k % 4));
      chk("R6 beat read data", 64'(rdata), 64'(model[exp_a]));
    end
    chk("R5 wrap to start", 64'(acc_addr), 64'(base));
  endtask

  task automatic t_idle();
    logic [AW-1:0] a0 = acc_addr;
    logic [1:0]    b0 = beat;
    logic [WW-1:0] r0 = rdata;
    drive(0, 0, 8'h33, 0, 0, 4'h0, rnd_word());
    chk("R9 idle addr", 64'(acc_addr), 64'(a0));
    chk("R9 idle beat", 64'(beat), 64'(b0));
    chk("R9 idle rdata", 64'(rdata), 64'(r0));
    drive(1, 0, a0, 0, 1, 4'hF, '0);
    chk("R9 idle no write", 64'(rdata), 64'(model[a0]));
    drive(1, 0, 8'h33, 0, 1, 4'hF, '0);
    chk("R9 idle no write 33", 64'(rdata), 64'(model[8'h33]));
  endtask

  task automatic t_restart();
    drive(1, 0, 8'h42, 1, 1, 4'hF, '0);
    drive(0, 1, 8'h00, 1, 1, 4'hF, '0);
    drive(1, 1, 8'h9D, 0, 1, 4'hF, '0);
    chk("R2 restart addr", 64'(acc_addr), 64'h9D);
    chk("R2 restart beat", 64'(beat), 64'd0);
    chk("R2 restart data", 64'(rdata), 64'(model[8'h9D]));
    drive(0, 1, 8'h00, 1, 1, 4'hF, '0);
    chk("R4 after restart linear", 64'(acc_addr), 64'h9E);
  endtask

  task automatic t_read_ignores();
    drive(1, 0, 8'h77, 0, 1, 4'h0, rnd_word());
    chk("R6 read with lanes low", 64'(rdata), 64'(model[8'h77]));
    drive(1, 0, 8'h77, 0, 1, 4'hF, '0);
    chk("R6 memory unchanged", 64'(rdata), 64'(model[8'h77]));
  endtask

  task automatic t_no_bytes();
    logic [WW-1:0] r0;
    drive(1, 0, 8'h21, 0, 1, 4'hF, '0);
    r0 = rdata;
    drive(1, 0, 8'h21, 0, 0, 4'hF, ~model[8'h21]);
    chk("R8 rdata held in write", 64'(rdata), 64'(r0));
    drive(1, 0, 8'h21, 0, 1, 4'hF, '0);
    chk("R7 no-lane write", 64'(rdata), 64'(model[8'h21]));
  endtask

  task automatic t_masks();
    for (int i = 0; i < 48; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      logic [3:0] m = (i < 16) ? 4'(i) : 4'($urandom);
      logic [WW-1:0] d = rnd_word();
      drive(1, 0, a, 0, 0, m, d);
      for (int l = 0; l < 4; l++)
        if (!m[l]) model[a][l*9 +: 9] = d[l*9 +: 9];
      drive(1, 0, a, 0, 1, 4'hF, '0);
      chk("R8 lane mask write", 64'(rdata), 64'(model[a]));
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  initial begin
    #35;
    t_reset();
    rst_n = 1'b1;
    t_fill();
    for (int o = 0; o < 2; o++)
      for (int s = 0; s < 4; s++) begin
        t_burst(1'(o), 2'(s));
        t_idle();
      end
    t_restart();
    t_read_ignores();
    t_no_bytes();
    t_masks();
    summary();
  end
endmodule